// File: doc/BRIEF.md
# Self-Clocked Converter Result Transmitter

This block is the digital output side of a converter that sends its own results over a two-wire link: it drives both the serial clock and the serial data line. A counter stands in for the analog conversion. While it runs, a stub converter can present a 24-bit result word with a load strobe. When the conversion time runs out, the block pulls both lines low to signal that a result is ready. After a short idle gap it generates its own serial clock and shifts the word out, most significant bit first. As soon as the frame ends, the next conversion starts.

The clock mode is chosen once, in the first cycle after reset, by reading the clock pin. A weak pull-up that leaves the pin high selects the self-clocked mode. A host that holds the pin low selects a mode in which the host supplies the clock edges. The active-low chip select puts both lines in high impedance while it is high. The host can briefly lower chip select during the idle state to read the ready flag without starting a frame. Each line has its own output enable, so the high-impedance intervals can be observed.

Top module: `adc_selfclk_tx`

## Requirements
- R1: In the first clock after reset is released, the block samples `sck_pin_in`: high selects self-clocked mode (`ext_mode`=0) and low selects host-clocked mode (`ext_mode`=1). The mode stays fixed until the next reset.
- R2: While a conversion runs (`conv_busy`=1), `sdo_o` is 1, and in self-clocked mode `sck_o` is also 1.
- R3: A conversion lasts exactly CONV_CYCLES clocks. In the clock after the last one, `conv_busy` drops and both `sdo_o` and `sck_o` go to 0, which is the idle state with the ready flag shown.
- R4: A `res_load` strobe captures `res_word` only while `conv_busy`=1. A strobe while not busy has no effect, and the next frame repeats the last captured word.
- R5: In self-clocked idle, a frame starts only after `csel_n` has been low for HALF_DIV consecutive clocks. A shorter low pulse shows `sdo_o`=0 and leaves the block idle, with `sck_o` low and no frame started.
- R6: In self-clocked mode, `sck_o` alternates between high and low, each phase lasting HALF_DIV clocks. It gives WORD_W rising edges per frame. `sdo_o` changes only in the clock where `sck_o` falls, so the bit present at rising edge k is frame bit WORD_W-k.
- R7: Frame bit 23, sent first, is always 0 (the ready flag), whatever bit 23 of the loaded word is. Frame bits 22..0 are word bits 22..0, most significant first.
- R8: After the last rising edge, `sck_o` stays high for HALF_DIV clocks. The next conversion then starts: `conv_busy`=1, `sdo_o`=1, and `sck_o` stays high with no low pulse.
- R9: `sdo_oe` equals the inverse of `csel_n`. `sck_oe` is 1 only in self-clocked mode while `csel_n` is low, and never in the reset-sampling clock.
- R10: In host-clocked mode, `sck_oe` stays 0. A host rising edge on `sck_pin_in` while idle with `csel_n` low starts the frame, each host falling edge advances `sdo_o` by one bit, and the WORD_W-th host rising edge ends the frame and starts a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on) |
| csel_n | input | 1 | Active-low chip select from host |
| sck_pin_in | input | 1 | Value read back from the clock pin (pull-up level or host clock) |
| res_load | input | 1 | Result load strobe from the stub converter |
| res_word | input | 24 | Result word: bit 22 channel, then sign, range, data |
| conv_busy | output | 1 | Conversion in progress; results may be loaded |
| sck_o | output | 1 | Self-generated serial clock level |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdo_o | output | 1 | Serial data / ready-flag level |
| sdo_oe | output | 1 | Drive enable for the data pin |
| ext_mode | output | 1 | 1 when host-clocked mode was selected at reset |

## Verification
A wrong phase, divider or bit counter inside the block shows up at the pins within one clock. The clock level, the data level or `conv_busy` then stops matching the cycle model, and in most cases a whole half-period passes before the next edge would hide it. A corrupted shift register or held word does not change the timing. It only appears as a wrong bit at a rising edge of the serial clock, so the received 24-bit frame is compared against the loaded word at the end of each frame. A wrong mode latch shows on `ext_mode` and `sck_oe` in the first clock after reset.

// File: rtl/adc_selfclk_pkg.sv
package adc_selfclk_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_CONV  = 2'd1,
        ST_SLEEP = 2'd2,
        ST_SHIFT = 2'd3
    } tx_state_e;
endpackage

// File: rtl/adc_selfclk_span.sv
// Counts enabled clocks and pulses tick on the LEN-th one; clears while disabled.
module adc_selfclk_span #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(LEN - 1));
        cnt_d = '0;
        if (en && !tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/adc_selfclk_edge.sv
// Registers the pin once and reports rising and falling transitions.
module adc_selfclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin;
        rise   = pin && !prev_q;
        fall   = !pin && prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/adc_selfclk_tx.sv
module adc_selfclk_tx #(
    parameter int CONV_CYCLES = 40,
    parameter int HALF_DIV    = 3,
    parameter int WORD_W      = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csel_n,
    input  logic              sck_pin_in,
    input  logic              res_load,
    input  logic [WORD_W-1:0] res_word,
    output logic              conv_busy,
    output logic              sck_o,
    output logic              sck_oe,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic              ext_mode
);
    import adc_selfclk_pkg::*;

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int MSB   = WORD_W - 1;

    typedef struct packed {
        tx_state_e         state;
        logic              ext;
        logic              sck;
        logic [CNT_W-1:0]  rises;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] word;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    logic conv_done, half_tick, host_rise, host_fall;
    logic half_en;

    assign half_en = !r_q.ext &&
                     (((r_q.state == ST_SLEEP) && !csel_n) || (r_q.state == ST_SHIFT));

    adc_selfclk_span #(.LEN(CONV_CYCLES)) u_conv_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.state == ST_CONV),
        .tick  (conv_done)
    );

    adc_selfclk_span #(.LEN(HALF_DIV)) u_half_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (half_en),
        .tick  (half_tick)
    );

    adc_selfclk_edge u_host_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (sck_pin_in),
        .rise  (host_rise),
        .fall  (host_fall)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_INIT: begin
                r_d.ext   = !sck_pin_in;
                r_d.state = ST_CONV;
            end
            ST_CONV: begin
                if (conv_done) begin
                    r_d.state   = ST_SLEEP;
                    r_d.sck     = 1'b0;
                    r_d.sh      = r_q.word;
                    r_d.sh[MSB] = 1'b0;
                end
                if (res_load) r_d.word = res_word;
            end
            ST_SLEEP: begin
                if (!csel_n && (r_q.ext ? host_rise : half_tick)) begin
                    r_d.state = ST_SHIFT;
                    r_d.sck   = 1'b1;
                    r_d.rises = CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                if (r_q.ext) begin
                    if (host_rise) begin
                        if (r_q.rises == CNT_W'(WORD_W - 1)) r_d.state = ST_CONV;
                        else                                  r_d.rises = r_q.rises + 1'b1;
                    end else if (host_fall) begin
                        r_d.sh = {r_q.sh[MSB-1:0], 1'b1};
                    end
                end else if (half_tick) begin
                    if (r_q.sck) begin
                        if (r_q.rises == CNT_W'(WORD_W)) begin
                            r_d.state = ST_CONV;
                        end else begin
                            r_d.sck = 1'b0;
                            r_d.sh  = {r_q.sh[MSB-1:0], 1'b1};
                        end
                    end else begin
                        r_d.sck   = 1'b1;
                        r_d.rises = r_q.rises + 1'b1;
                    end
                end
            end
            default: r_d.state = ST_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_INIT;
            r_q.ext   <= 1'b0;
            r_q.sck   <= 1'b1;
            r_q.rises <= '0;
            r_q.sh    <= '1;
            r_q.word  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign conv_busy = (r_q.state == ST_CONV);
    assign sck_o     = r_q.sck;
    assign sdo_o     = ((r_q.state == ST_INIT) || (r_q.state == ST_CONV)) ? 1'b1 : r_q.sh[MSB];
    assign sdo_oe    = !csel_n;
    assign sck_oe    = !csel_n && !r_q.ext && (r_q.state != ST_INIT);
    assign ext_mode  = r_q.ext;
endmodule

// File: rtl/adc_selfclk_tx_chk.sv
module adc_selfclk_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_busy,
    input logic sdo_o,
    input logic sck_o,
    input logic ext_mode
);
    // R1: mode latched once, never changes after a conversion has begun
    a_r1_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> $stable(ext_mode));

    // R2: data line high throughout a conversion
    a_r2_busy_sdo_high: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> sdo_o);

    // R3: end of conversion pulls both lines low
    a_r3_sleep_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_busy) |-> (!sdo_o && !sck_o));

    // R6: in self-clocked output, data moves only with a falling clock
    a_r6_sdo_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && !conv_busy && !$past(conv_busy) && !$stable(sdo_o)) |-> $fell(sck_o));

    // R8: conversion entered with clock already high and kept high
    a_r8_sck_high_into_conv: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(conv_busy) && !ext_mode) |-> (sck_o && $past(sck_o)));
endmodule

bind adc_selfclk_tx adc_selfclk_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_busy (conv_busy),
    .sdo_o     (sdo_o),
    .sck_o     (sck_o),
    .ext_mode  (ext_mode)
);

// File: tb/adc_selfclk_tx_tb.sv
`timescale 1ns/1ps
module adc_selfclk_tx_tb;
    localparam int CONV = 40;
    localparam int H    = 3;
    localparam int W    = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic csel_n = 1'b0;
    logic pin = 1'b1;
    logic res_load = 1'b0;
    logic [W-1:0] res_word = '0;
    logic conv_busy, sck_o, sck_oe, sdo_o, sdo_oe, ext_mode;

    always #4 clk = ~clk;

    adc_selfclk_tx #(.CONV_CYCLES(CONV), .HALF_DIV(H), .WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .csel_n(csel_n), .sck_pin_in(pin),
        .res_load(res_load), .res_word(res_word), .conv_busy(conv_busy),
        .sck_o(sck_o), .sck_oe(sck_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
        .ext_mode(ext_mode)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    int       m_ph = 0;      // 0 sample,1 convert,2 idle,3 output
    bit       m_ext = 0, m_sck = 1, m_prev = 0;
    int       m_t = 0, m_div = 0, m_rises = 0;
    bit [W-1:0] m_word = '0;
    bit       q[$];
    bit       last_sck = 1;
    bit [W-1:0] rx = '0;
    int       rx_n = 0;

    always @(posedge clk) begin
        bit rise, fall, e_sdo;
        if (!rst_n) begin
            m_ph = 0; m_ext = 0; m_sck = 1; m_prev = 0;
            m_t = 0; m_div = 0; m_rises = 0; m_word = '0; q.delete();
        end else begin
            rise = pin && !m_prev;
            fall = !pin && m_prev;
            case (m_ph)
                0: begin m_ext = !pin; m_ph = 1; m_t = 0; end
                1: begin
                    if (m_t == CONV - 1) begin
                        m_ph = 2; m_sck = 0; m_div = 0; q.delete();
                        for (int i = W - 1; i >= 0; i--) q.push_back(i == W - 1 ? 1'b0 : m_word[i]);
                    end else m_t++;
                    if (res_load) m_word = res_word;
                end
                2: begin
                    if (!m_ext) begin
                        if (!csel_n) begin
                            if (m_div == H - 1) begin m_ph = 3; m_sck = 1; m_rises = 1; m_div = 0; end
                            else m_div++;
                        end else m_div = 0;
                    end else if (!csel_n && rise) begin
                        m_ph = 3; m_rises = 1; m_sck = 1;
                    end
                end
                default: begin
                    if (!m_ext) begin
                        if (m_div == H - 1) begin
                            m_div = 0;
                            if (m_sck) begin
                                if (m_rises == W) begin m_ph = 1; m_t = 0; end
                                else begin m_sck = 0; void'(q.pop_front()); end
                            end else begin m_sck = 1; m_rises++; end
                        end else m_div++;
                    end else begin
                        if (rise) begin
                            if (m_rises == W - 1) begin m_ph = 1; m_t = 0; end
                            else m_rises++;
                        end else if (fall) void'(q.pop_front());
                    end
                end
            endcase
            m_prev = pin;
        end
        #2;
        if (rst_n && !done_flag) begin
            e_sdo = (m_ph <= 1) ? 1'b1 : ((m_ph == 2 || q.size() == 0) ? 1'b0 : q[0]);
            chk("R3 busy", conv_busy, (m_ph == 1));
            chk("R6 sdo", sdo_o, e_sdo);
            if (!m_ext) chk("R6 sck", sck_o, m_sck);
            chk("R9 sdo_oe", sdo_oe, !csel_n);
            chk("R9 sck_oe", sck_oe, (!csel_n && !m_ext && m_ph != 0));
            chk("R1 mode", ext_mode, m_ext);
            if (!ext_mode && sck_o && !last_sck && !csel_n) begin
                rx = {rx[W-2:0], sdo_o};
                rx_n++;
            end
            if (!conv_busy && ($past(1'b1) == 1'b1) && m_ph == 2 && m_div == 0 && csel_n) ; // idle, nothing
        end
        last_sck = sck_o;
    end

    function automatic bit [W-1:0] frame_of(bit [W-1:0] w);
        return {1'b0, w[W-2:0]};
    endfunction

    task automatic wait_busy(bit val, string tag);
        int k = 0;
        while (conv_busy !== val && k < 2000) begin @(negedge clk); k++; end
        chk(tag, conv_busy, val);
    endtask

    task automatic load_word(bit [W-1:0] w);
        @(negedge clk); res_load = 1'b1; res_word = w;
        @(negedge clk); res_load = 1'b0;
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        finish_run();
    end

    initial begin
        bit [W-1:0] host_rx;
        // ---- self-clocked mode ----
        pin = 1'b1; csel_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 reset sdo", sdo_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 internal selected", ext_mode, 1'b0);
        chk("R2 busy after reset", conv_busy, 1'b1);
        load_word(24'hA5C3F0);
        chk("R2 sdo high in conversion", sdo_o, 1'b1);
        chk("R2 sck high in conversion", sck_o, 1'b1);
        wait_busy(0, "R3 conversion end");
        chk("R3 sdo low in idle", sdo_o, 1'b0);
        rx_n = 0;
        wait_busy(1, "R8 restart after frame");
        chk("R6 rising edge count", rx_n, W);
        chk("R7 frame with forced flag", rx, frame_of(24'hA5C3F0));
        chk("R8 sck high at restart", sck_o, 1'b1);

        load_word(24'h3C0FF1);
        wait_busy(0, "R3 second end");
        rx_n = 0;
        load_word(24'h7FFFFF);           // not busy: must be ignored
        wait_busy(1, "R8 second restart");
        chk("R7 second frame", rx, frame_of(24'h3C0FF1));
        wait_busy(0, "R3 third end");
        rx_n = 0;
        wait_busy(1, "R8 third restart");
        chk("R4 idle load ignored", rx, frame_of(24'h3C0FF1));

        // ---- status test with chip select ----
        @(negedge clk); csel_n = 1'b1;
        @(negedge clk);
        chk("R9 sdo hi-z", sdo_oe, 1'b0);
        chk("R9 sck hi-z", sck_oe, 1'b0);
        wait_busy(0, "R3 end under deselect");
        repeat (5) @(negedge clk);
        chk("R5 idle held while deselected", sck_o, 1'b0);
        csel_n = 1'b0;
        @(negedge clk);
        chk("R5 status flag visible", sdo_o, 1'b0);
        chk("R9 sdo driven", sdo_oe, 1'b1);
        csel_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R5 short pulse no start sck", sck_o, 1'b0);
        chk("R5 short pulse still idle", conv_busy, 1'b0);
        rx_n = 0;
        csel_n = 1'b0;
        wait_busy(1, "R5 frame after long select");
        chk("R5 frame count", rx_n, W);
        chk("R5 frame data", rx, frame_of(24'h3C0FF1));

        // ---- host-clocked mode ----
        @(negedge clk); rst_n = 1'b0; pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 external selected", ext_mode, 1'b1);
        chk("R10 sck never driven", sck_oe, 1'b0);
        load_word(24'hD2B496);
        wait_busy(0, "R10 conversion end");
        repeat (3) @(negedge clk);
        host_rx = '0;
        for (int i = 0; i < W; i++) begin
            host_rx = {host_rx[W-2:0], sdo_o};
            pin = 1'b1;
            repeat (2) @(negedge clk);
            chk("R10 sck_oe low during frame", sck_oe, 1'b0);
            pin = 1'b0;
            repeat (2) @(negedge clk);
        end
        chk("R10 host frame data", host_rx, frame_of(24'hD2B496));
        chk("R10 conversion restarted", conv_busy, 1'b1);
        chk("R10 sdo high after frame", sdo_o, 1'b1);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule